// File: doc/BRIEF.md
# Command/Data Serial Display Receiver

This block sits on the display-controller side of a write-only four-wire serial link. A host lowers an active-low select line, toggles a serial clock and presents one data bit per clock, most significant bit first, together with a side-band kind line. The kind line tells the receiver whether the byte is a controller command or a pixel byte for display memory. The receiver oversamples all four pins in its own system clock domain. It does this through multi-stage synchronizers and finds serial-clock rising edges in the synchronized copy.

Every eighth rising edge while the link is selected completes a byte. On that edge the kind line is captured together with the last bit. A low kind level sends the byte out as a one-cycle command strobe. A high kind level produces a one-cycle display-memory write. That write uses a 10-bit address that starts at zero, advances after each memory write and wraps at the end of the address space. Deselecting the link mid-byte throws the partial byte away.

Top module: `cmdata_spi_rx`

## Requirements
- R1: After reset, `cmd_valid_o` and `mem_we_o` are low, and `cmd_byte_o`, `mem_wdata_o` and `mem_addr_o` are zero.
- R2: Bits are taken on rising edges of `ser_clk_i`, and the first bit of a byte becomes bit 7 of the delivered byte.
- R3: A completed byte whose kind level is 1 appears on `mem_wdata_o` with `mem_we_o` high. A completed byte whose kind level is 0 appears on `cmd_byte_o` with `cmd_valid_o` high.
- R4: The kind level is read only at the eighth rising edge of a byte. Its value during the first seven edges has no effect on routing.
- R5: Each completed byte raises exactly one of `cmd_valid_o` or `mem_we_o`, for exactly one system cycle. The two are never high together.
- R6: While `ser_sel_n_i` is high, edges on `ser_clk_i` and values on `ser_data_i` produce no output and do not shift the bit alignment of the next selected byte.
- R7: Raising `ser_sel_n_i` before the eighth edge discards the partial byte without any strobe. The next selected byte starts at bit 7.
- R8: The first memory write after reset uses address 0. Each memory write uses the previous memory-write address plus one. Command bytes leave the address unchanged.
- R9: After a memory write at address 1023, the next memory write uses address 0.
- R10: Several bytes sent within one select-low window are each routed by their own kind level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_sel_n_i | input | 1 | Link select, active low, asynchronous to clk |
| ser_clk_i | input | 1 | Serial clock, bits taken on its rising edge |
| ser_data_i | input | 1 | Serial data bit, MSB first |
| ser_kind_i | input | 1 | Byte kind: 1 memory data, 0 command |
| cmd_byte_o | output | 8 | Last command byte received |
| cmd_valid_o | output | 1 | One-cycle strobe for a new command byte |
| mem_wdata_o | output | 8 | Display-memory write data |
| mem_addr_o | output | 10 | Display-memory write address |
| mem_we_o | output | 1 | One-cycle display-memory write enable |

## Verification
Single command and single data bytes with asymmetric values (A5, 3C) separate correct MSB-first assembly and routing from bit reversal or swapped outputs. A mixed burst inside one select window, and bytes whose kind level flips just before the final edge, show whether the kind line is read per byte and only at the last edge. Clock and data activity while deselected, followed by an aborted five-bit byte, reveal leaked strobes and stale bit counts through the value of the next full byte. A run of over a thousand data bytes checks the address sequence across the wrap from 1023 to 0.

// File: rtl/dspi_pkg.sv
package dspi_pkg;

  // Synchronized copy of the link pins, kept together so every pin
  // sees the same number of flop stages.
  typedef struct packed {
    logic kind;
    logic data;
    logic sclk;
    logic sel_n;
  } dspi_pins_t;

  localparam int PIN_COUNT = $bits(dspi_pins_t);

  // Idle level of each pin: deselected link, clock low.
  localparam dspi_pins_t PINS_IDLE = '{kind: 1'b0, data: 1'b0, sclk: 1'b0, sel_n: 1'b1};

endpackage

// File: rtl/dspi_sync.sv
module dspi_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= IDLE_VAL;
          else     stage_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= IDLE_VAL;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/dspi_shifter.sv
module dspi_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n_s,
  input  logic              sclk_s,
  input  logic              data_s,
  input  logic              kind_s,
  output logic              done_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              kind_o
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic              sclk_prev;
  logic              rise;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] next_shreg;

  assign rise       = sclk_s & ~sclk_prev;
  assign next_shreg = {shreg[DATA_W-2:0], data_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      bit_cnt   <= '0;
      shreg     <= '0;
      done_o    <= 1'b0;
      byte_o    <= '0;
      kind_o    <= 1'b0;
    end else begin
      sclk_prev <= sclk_s;
      done_o    <= 1'b0;
      if (sel_n_s) begin
        bit_cnt <= '0;
      end else if (rise) begin
        shreg <= next_shreg;
        if (bit_cnt == LAST_BIT) begin
          bit_cnt <= '0;
          done_o  <= 1'b1;
          byte_o  <= next_shreg;
          kind_o  <= kind_s;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  AST_DESEL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    sel_n_s |=> (bit_cnt == '0)); // R7
  AST_DESEL_SILENT: assert property (@(posedge clk) disable iff (rst)
    sel_n_s |=> !done_o); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R5

endmodule

// File: rtl/dspi_router.sv
module dspi_router #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              kind_i,
  output logic [DATA_W-1:0] cmd_byte_o,
  output logic              cmd_valid_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o
);

  logic [ADDR_W-1:0] wr_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_byte_o  <= '0;
      cmd_valid_o <= 1'b0;
      mem_wdata_o <= '0;
      mem_addr_o  <= '0;
      mem_we_o    <= 1'b0;
      wr_ptr      <= '0;
    end else begin
      cmd_valid_o <= 1'b0;
      mem_we_o    <= 1'b0;
      if (done_i) begin
        if (kind_i) begin
          mem_wdata_o <= byte_i;
          mem_addr_o  <= wr_ptr;
          mem_we_o    <= 1'b1;
          wr_ptr      <= wr_ptr + 1'b1;
        end else begin
          cmd_byte_o  <= byte_i;
          cmd_valid_o <= 1'b1;
        end
      end
    end
  end

  AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid_o && mem_we_o)); // R5
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |=> !mem_we_o); // R5
  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |=> !cmd_valid_o); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> (wr_ptr == ADDR_W'(mem_addr_o + 1'b1))); // R9
  AST_CMD_KEEPS_ADDR: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |-> $stable(wr_ptr)); // R8

endmodule

// File: rtl/cmdata_spi_rx.sv
module cmdata_spi_rx #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_sel_n_i,
  input  logic              ser_clk_i,
  input  logic              ser_data_i,
  input  logic              ser_kind_i,
  output logic [DATA_W-1:0] cmd_byte_o,
  output logic              cmd_valid_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o
);

  import dspi_pkg::*;

  dspi_pins_t        pins_raw;
  dspi_pins_t        pins_s;
  logic              done;
  logic [DATA_W-1:0] byte_v;
  logic              kind_v;

  assign pins_raw = '{kind: ser_kind_i, data: ser_data_i, sclk: ser_clk_i, sel_n: ser_sel_n_i};

  dspi_sync #(
    .WIDTH(PIN_COUNT),
    .STAGES(SYNC_STAGES),
    .IDLE_VAL(PINS_IDLE)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .async_i(pins_raw),
    .sync_o(pins_s)
  );

  dspi_shifter #(
    .DATA_W(DATA_W)
  ) u_shift (
    .clk(clk),
    .rst(rst),
    .sel_n_s(pins_s.sel_n),
    .sclk_s(pins_s.sclk),
    .data_s(pins_s.data),
    .kind_s(pins_s.kind),
    .done_o(done),
    .byte_o(byte_v),
    .kind_o(kind_v)
  );

  dspi_router #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_route (
    .clk(clk),
    .rst(rst),
    .done_i(done),
    .byte_i(byte_v),
    .kind_i(kind_v),
    .cmd_byte_o(cmd_byte_o),
    .cmd_valid_o(cmd_valid_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_addr_o(mem_addr_o),
    .mem_we_o(mem_we_o)
  );

endmodule

// File: tb/sim_cmdata_spi_rx.sv
module sim_cmdata_spi_rx;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_sel_n = 1'b1;
  logic       ser_clk = 1'b0;
  logic       ser_data = 1'b0;
  logic       ser_kind = 1'b0;
  logic [7:0] cmd_byte_o;
  logic       cmd_valid_o;
  logic [7:0] mem_wdata_o;
  logic [9:0] mem_addr_o;
  logic       mem_we_o;

  int checks = 0;
  int fails = 0;
  int exp_ptr = 0;
  int wide_pulses = 0;
  int both_high = 0;
  bit finished = 1'b0;
  logic prev_cmd = 1'b0;
  logic prev_we = 1'b0;
  logic [18:0] evq[$];

  always #10 clk = ~clk;

  cmdata_spi_rx u0 (
    .clk(clk), .rst(rst),
    .ser_sel_n_i(ser_sel_n), .ser_clk_i(ser_clk),
    .ser_data_i(ser_data), .ser_kind_i(ser_kind),
    .cmd_byte_o(cmd_byte_o), .cmd_valid_o(cmd_valid_o),
    .mem_wdata_o(mem_wdata_o), .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o)
  );

  // Event log: {kind, addr, byte}
  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_valid_o) evq.push_back({1'b0, 10'd0, cmd_byte_o});
      if (mem_we_o)    evq.push_back({1'b1, mem_addr_o, mem_wdata_o});
      if ((cmd_valid_o && prev_cmd) || (mem_we_o && prev_we)) wide_pulses++;
      if (cmd_valid_o && mem_we_o) both_high++;
      prev_cmd = cmd_valid_o;
      prev_we  = mem_we_o;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_bit(input logic b, input logic k);
    ser_data = b;
    ser_kind = k;
    repeat (5) @(negedge clk);
    ser_clk = 1'b1;
    repeat (5) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] v, input logic k_last, input logic k_early);
    for (int i = 0; i < 8; i++) put_bit(v[7-i], (i == 7) ? k_last : k_early);
  endtask

  task automatic select_link();
    ser_sel_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic release_link();
    repeat (4) @(negedge clk);
    ser_sel_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic expect_cmd(input string req, input logic [7:0] b);
    logic [18:0] e;
    if (evq.size() == 0) begin
      check(req, 32'hDEAD, {24'd0, b});
    end else begin
      e = evq.pop_front();
      check(req, {13'd0, e}, {13'd0, 1'b0, 10'd0, b});
    end
  endtask

  task automatic expect_mem(input string req, input logic [7:0] b);
    logic [18:0] e;
    logic [9:0] a;
    a = exp_ptr[9:0];
    exp_ptr = (exp_ptr + 1) % 1024;
    if (evq.size() == 0) begin
      check(req, 32'hDEAD, {14'd0, a, b});
    end else begin
      e = evq.pop_front();
      check(req, {13'd0, e}, {13'd0, 1'b1, a, b});
    end
  endtask

  task automatic expect_none(input string req);
    check(req, evq.size(), 0);
    evq.delete();
  endtask

  task automatic t_reset();
    check("R1 cmd_valid", cmd_valid_o, 0);
    check("R1 mem_we", mem_we_o, 0);
    check("R1 outputs", {cmd_byte_o, mem_wdata_o, mem_addr_o}, 0);
    expect_none("R1 no events");
  endtask

  task automatic t_single();
    select_link(); put_byte(8'hA5, 1'b0, 1'b0); release_link();
    expect_cmd("R2 R3 command A5", 8'hA5);
    select_link(); put_byte(8'h3C, 1'b1, 1'b1); release_link();
    expect_mem("R3 R8 data 3C", 8'h3C);
    expect_none("R5 one event per byte");
  endtask

  task automatic t_burst();
    select_link();
    put_byte(8'h81, 1'b0, 1'b0);
    put_byte(8'h11, 1'b1, 1'b1);
    put_byte(8'h22, 1'b1, 1'b1);
    put_byte(8'h0F, 1'b0, 1'b0);
    put_byte(8'hF0, 1'b1, 1'b1);
    release_link();
    expect_cmd("R10 burst cmd 81", 8'h81);
    expect_mem("R10 burst data 11", 8'h11);
    expect_mem("R10 burst data 22", 8'h22);
    expect_cmd("R10 burst cmd 0F", 8'h0F);
    expect_mem("R8 cmd keeps addr", 8'hF0);
    expect_none("R10 burst count");
  endtask

  task automatic t_kind_late();
    select_link();
    put_byte(8'h6E, 1'b0, 1'b1);
    put_byte(8'h91, 1'b1, 1'b0);
    release_link();
    expect_cmd("R4 late low kind", 8'h6E);
    expect_mem("R4 late high kind", 8'h91);
  endtask

  task automatic t_deselect_noise();
    for (int i = 0; i < 11; i++) put_bit(i[0], 1'b1);
    repeat (12) @(negedge clk);
    expect_none("R6 deselected activity");
    select_link(); put_byte(8'h5A, 1'b1, 1'b1); release_link();
    expect_mem("R6 alignment after noise", 8'h5A);
  endtask

  task automatic t_abort();
    select_link();
    for (int i = 0; i < 5; i++) put_bit(1'b1, 1'b0);
    release_link();
    expect_none("R7 partial discarded");
    select_link(); put_byte(8'hC3, 1'b0, 1'b0); release_link();
    expect_cmd("R7 next byte aligned", 8'hC3);
  endtask

  task automatic t_wrap();
    int n;
    int bad;
    n = 1023 - exp_ptr;
    select_link();
    for (int i = 0; i < n; i++) put_byte(i[7:0], 1'b1, 1'b1);
    release_link();
    check("R8 run length", evq.size(), n);
    bad = 0;
    for (int i = 0; i < n; i++) begin
      logic [18:0] e;
      if (evq.size() != 0) begin
        e = evq.pop_front();
        if (e !== {1'b1, exp_ptr[9:0], i[7:0]}) bad++;
      end
      exp_ptr = (exp_ptr + 1) % 1024;
    end
    check("R8 run sequence mismatches", bad, 0);
    select_link();
    put_byte(8'hEE, 1'b1, 1'b1);
    put_byte(8'h77, 1'b1, 1'b1);
    release_link();
    expect_mem("R9 last address 1023", 8'hEE);
    expect_mem("R9 wrap to 0", 8'h77);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    t_single();
    t_burst();
    t_kind_late();
    t_deselect_noise();
    t_abort();
    t_wrap();
    check("R5 strobe width", wide_pulses, 0);
    check("R5 exclusive strobes", both_high, 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule